// File: doc/BRIEF.md
# Transparent Binary-Synchronous Frame Sender

This block turns one payload buffer into a transparent binary-synchronous frame on a byte-wide transmit path. Each transmitter-ready request from the line side produces exactly one frame byte. The byte appears on a registered output with a strobe in the following cycle. Payload bytes are pulled from a show-ahead byte source. The read strobe is raised in the same cycle as the request that consumes the byte. The block keeps a running reflected CRC-16 over the protected bytes.

A frame opens with a fixed preamble of three SYN bytes, then DLE and STX. Payload bytes follow. A payload byte equal to DLE is sent twice, and only the first copy is protected by the CRC. The frame closes with DLE and ETX, and ETX is protected. The CRC follows, low byte first, then one all-ones pad byte, and a completion pulse marks the end. Send-enable tells the line to keep transmitting. It is released when a ready request finds the block idle with no buffer pending.

Top module: `bsc_frame_sender`

## Requirements
- R1: After reset, txStrobe, sendEnable, frameDone and payloadRead are all low and no buffer is pending.
- R2: While a frame is in progress, each cycle with txReady high yields exactly one byte on txByte with txStrobe high in the next cycle. No byte is produced without a request.
- R3: The first five bytes of a frame are SYN (8'h16) three times, then DLE (8'h10), then STX (8'h02). None of them is protected by the CRC, and the CRC is cleared when the first SYN is sent.
- R4: Payload bytes are sent in source order. payloadRead is high in the same cycle as the txReady that consumes payloadByte, and it is asserted exactly byteCount times per frame.
- R5: A payload byte equal to DLE (8'h10) is followed, on the next request, by a second DLE that does not enter the CRC and does not read the source.
- R6: After the last payload byte the frame carries DLE (8'h10), which is unprotected, then ETX (8'h83), which is protected.
- R7: The CRC is the reflected polynomial 16'hA001 with initial value zero, updated LSB-first per byte over the payload bytes and ETX. It is sent low byte first, then high byte.
- R8: After the CRC high byte, the next request sends 8'hFF with frameDone high for that one cycle, and the block returns to idle.
- R9: sendEnable rises together with the strobe of the first SYN. It falls, with no byte strobed, in the cycle after a request finds the block idle with nothing pending.
- R10: startReq is accepted only in the idle state, where it latches byteCount and marks a buffer pending. A startReq during a frame has no effect on that frame and leaves nothing pending.
- R11: A zero-length buffer yields SYN SYN SYN DLE STX DLE ETX, CRC low, CRC high, then 8'hFF.
- R12: In the idle state, a startReq in the same cycle as txReady starts the frame on that request, using the byteCount presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| startReq | input | 1 | Buffer-valid / start request |
| byteCount | input | CNT_W | Payload length, latched with startReq |
| txReady | input | 1 | Transmitter-ready request, one byte each |
| payloadByte | input | 8 | Current payload byte from the show-ahead source |
| txByte | output | 8 | Frame byte to the line |
| txStrobe | output | 1 | txByte is new this cycle |
| sendEnable | output | 1 | Line transmitter enable |
| payloadRead | output | 1 | Consume payloadByte this cycle |
| frameDone | output | 1 | One-cycle completion pulse with the pad byte |

## Verification
The start request and a transmitter-ready request can both reach the idle state in the same cycle. The block must treat the buffer as pending on that very request, so it sends the first SYN, latches the count from that cycle and keeps send-enable high. The bench drives both strobes on the same clock with nothing pending. It then checks that the frame's byte stream matches the model exactly and that send-enable never dips. A start request raised in the middle of another frame is the opposite case. The bench checks that such a request leaves the frame intact, and that the next idle request drops send-enable instead of opening a new frame.

// File: rtl/bsc_tx_pkg.sv
package bsc_tx_pkg;

  localparam logic [7:0] SYN_CHAR = 8'h16;
  localparam logic [7:0] DLE_CHAR = 8'h10;
  localparam logic [7:0] STX_CHAR = 8'h02;
  localparam logic [7:0] ETX_CHAR = 8'h83;
  localparam logic [7:0] PAD_CHAR = 8'hFF;

  // next byte the sequencer will send on a ready request
  typedef enum logic [3:0] {
    S_IDLE, S_SYN2, S_SYN3, S_OPEN_DLE, S_OPEN_STX, S_BODY,
    S_ESC_DLE, S_CLOSE_ETX, S_CRC_LO, S_CRC_HI, S_PAD
  } txState_e;

  typedef enum logic [2:0] {
    SRC_SYN, SRC_DLE, SRC_STX, SRC_ETX, SRC_PAY, SRC_CRC_LO, SRC_CRC_HI, SRC_PAD
  } byteSrc_e;

  typedef struct packed {
    logic     emit;
    byteSrc_e src;
    logic     fold;
    logic     crcClear;
    logic     done;
  } dpCtrl_t;

endpackage

// File: rtl/bsc_tx_ctrl.sv
module bsc_tx_ctrl
  import bsc_tx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             txReady,
  input  logic [7:0]       payloadByte,
  output dpCtrl_t          dp,
  output logic             payloadRead,
  output logic             sendEnable
);

  txState_e         state, nextState;
  logic             pending;
  logic [CNT_W-1:0] remain;
  logic             bufAvail;
  logic             countZero;

  assign bufAvail  = pending | startReq;
  assign countZero = (remain == '0);

  always_comb begin
    nextState   = state;
    dp          = '0;
    dp.src      = SRC_PAD;
    payloadRead = 1'b0;
    if (txReady) begin
      unique case (state)
        S_IDLE: if (bufAvail) begin
          dp.emit = 1'b1; dp.src = SRC_SYN; dp.crcClear = 1'b1;
          nextState = S_SYN2;
        end
        S_SYN2:     begin dp.emit = 1'b1; dp.src = SRC_SYN; nextState = S_SYN3; end
        S_SYN3:     begin dp.emit = 1'b1; dp.src = SRC_SYN; nextState = S_OPEN_DLE; end
        S_OPEN_DLE: begin dp.emit = 1'b1; dp.src = SRC_DLE; nextState = S_OPEN_STX; end
        S_OPEN_STX: begin dp.emit = 1'b1; dp.src = SRC_STX; nextState = S_BODY; end
        S_BODY: begin
          dp.emit = 1'b1;
          if (countZero) begin
            dp.src = SRC_DLE;
            nextState = S_CLOSE_ETX;
          end else begin
            dp.src = SRC_PAY;
            dp.fold = 1'b1;
            payloadRead = 1'b1;
            nextState = (payloadByte == DLE_CHAR) ? S_ESC_DLE : S_BODY;
          end
        end
        S_ESC_DLE:   begin dp.emit = 1'b1; dp.src = SRC_DLE; nextState = S_BODY; end
        S_CLOSE_ETX: begin dp.emit = 1'b1; dp.src = SRC_ETX; dp.fold = 1'b1; nextState = S_CRC_LO; end
        S_CRC_LO:    begin dp.emit = 1'b1; dp.src = SRC_CRC_LO; nextState = S_CRC_HI; end
        S_CRC_HI:    begin dp.emit = 1'b1; dp.src = SRC_CRC_HI; nextState = S_PAD; end
        S_PAD:       begin dp.emit = 1'b1; dp.src = SRC_PAD; dp.done = 1'b1; nextState = S_IDLE; end
        default:     nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pending    <= 1'b0;
      remain     <= '0;
      sendEnable <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE) begin
        if (startReq) remain <= byteCount;
        if (txReady) begin
          pending    <= 1'b0;
          sendEnable <= bufAvail;
        end else if (startReq) begin
          pending <= 1'b1;
        end
      end else if (payloadRead) begin
        remain <= remain - 1'b1;
      end
    end
  end

endmodule

// File: rtl/bsc_tx_datapath.sv
module bsc_tx_datapath
  import bsc_tx_pkg::*;
#(
  parameter logic [15:0] CRC_POLY = 16'hA001
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    dp,
  input  logic [7:0] payloadByte,
  output logic [7:0] txByte,
  output logic       txStrobe,
  output logic       frameDone
);

  logic [15:0] crcReg;
  logic [7:0]  muxByte;

  function automatic logic [15:0] crcStep(input logic [15:0] cur, input logic [7:0] b);
    logic [15:0] acc;
    acc = cur ^ {8'h00, b};
    for (int k = 0; k < 8; k++) begin
      acc = acc[0] ? ((acc >> 1) ^ CRC_POLY) : (acc >> 1);
    end
    return acc;
  endfunction

  always_comb begin
    unique case (dp.src)
      SRC_SYN:    muxByte = SYN_CHAR;
      SRC_DLE:    muxByte = DLE_CHAR;
      SRC_STX:    muxByte = STX_CHAR;
      SRC_ETX:    muxByte = ETX_CHAR;
      SRC_PAY:    muxByte = payloadByte;
      SRC_CRC_LO: muxByte = crcReg[7:0];
      SRC_CRC_HI: muxByte = crcReg[15:8];
      default:    muxByte = PAD_CHAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= '0;
      txByte    <= '0;
      txStrobe  <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      txStrobe  <= dp.emit;
      frameDone <= dp.done;
      if (dp.emit) txByte <= muxByte;
      if (dp.crcClear)  crcReg <= '0;
      else if (dp.fold) crcReg <= crcStep(crcReg, muxByte);
    end
  end

endmodule

// File: rtl/bsc_frame_sender.sv
module bsc_frame_sender
  import bsc_tx_pkg::*;
#(
  parameter int          CNT_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'hA001
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             txReady,
  input  logic [7:0]       payloadByte,
  output logic [7:0]       txByte,
  output logic             txStrobe,
  output logic             sendEnable,
  output logic             payloadRead,
  output logic             frameDone
);

  dpCtrl_t dpCtl;

  bsc_tx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .byteCount(byteCount),
    .txReady(txReady), .payloadByte(payloadByte), .dp(dpCtl),
    .payloadRead(payloadRead), .sendEnable(sendEnable)
  );

  bsc_tx_datapath #(.CRC_POLY(CRC_POLY)) u_dp (
    .clk(clk), .rstN(rstN), .dp(dpCtl), .payloadByte(payloadByte),
    .txByte(txByte), .txStrobe(txStrobe), .frameDone(frameDone)
  );

endmodule

// File: rtl/bsc_tx_checker.sv
module bsc_tx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       txReady,
  input logic [7:0] txByte,
  input logic       txStrobe,
  input logic       sendEnable,
  input logic       payloadRead,
  input logic       frameDone
);

  AST_STROBE_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |-> $past(txReady)); // R2

  AST_READ_ON_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    payloadRead |-> txReady); // R4

  AST_READ_GIVES_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    payloadRead |=> txStrobe); // R4

  AST_DONE_WITH_PAD: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (txStrobe && txByte == 8'hFF)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R8

  AST_ENABLE_ON_SYN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sendEnable) |-> (txStrobe && txByte == 8'h16)); // R9

  AST_ENABLE_DROP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sendEnable) |-> (!txStrobe && $past(txReady))); // R9

endmodule

bind bsc_frame_sender bsc_tx_checker u_chk (
  .clk(clk), .rstN(rstN), .txReady(txReady), .txByte(txByte),
  .txStrobe(txStrobe), .sendEnable(sendEnable),
  .payloadRead(payloadRead), .frameDone(frameDone)
);

// File: tb/sim_bsc_frame_sender.sv
module sim_bsc_frame_sender;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [CNT_W-1:0] byteCount = '0;
  logic txReady = 1'b0;
  logic [7:0] payloadByte;
  logic [7:0] txByte;
  logic txStrobe, sendEnable, payloadRead, frameDone;

  always #2 clk = ~clk;

  bsc_frame_sender #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .byteCount(byteCount),
    .txReady(txReady), .payloadByte(payloadByte), .txByte(txByte),
    .txStrobe(txStrobe), .sendEnable(sendEnable), .payloadRead(payloadRead),
    .frameDone(frameDone)
  );

  logic [7:0] payMem [0:63];
  int rdIdx = 0;
  assign payloadByte = payMem[rdIdx % 64];
  always @(posedge clk) if (rstN && payloadRead) rdIdx <= rdIdx + 1;

  int vecCnt = 0;
  int errCnt = 0;
  int doneSeen = 0;
  bit finished = 0;

  logic [7:0] expQ [$];
  bit         expDoneQ [$];
  string      expTagQ [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'hA001;
    end
    return c;
  endfunction

  task automatic push(input logic [7:0] b, input string tag, input bit dn = 0);
    expQ.push_back(b);
    expTagQ.push_back(tag);
    expDoneQ.push_back(dn);
  endtask

  // lays payload into the source and queues the whole expected frame; returns byte total
  task automatic planFrame(input logic [7:0] pay [], output int total);
    logic [15:0] crc;
    crc = '0;
    total = 10;
    for (int k = 0; k < 3; k++) push(8'h16, "R3");
    push(8'h10, "R3");
    push(8'h02, "R3");
    for (int k = 0; k < pay.size(); k++) begin
      payMem[(rdIdx + k) % 64] = pay[k];
      push(pay[k], "R4");
      crc = refCrc(crc, pay[k]);
      total++;
      if (pay[k] == 8'h10) begin
        push(8'h10, "R5");
        total++;
      end
    end
    push(8'h10, "R6");
    push(8'h83, "R6");
    crc = refCrc(crc, 8'h83);
    push(crc[7:0], "R7");
    push(crc[15:8], "R7");
    push(8'hFF, "R8", 1'b1);
  endtask

  task automatic giveReady(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) txReady = 1'b1;
      @(negedge clk) txReady = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic startBuf(input int n);
    @(negedge clk) begin startReq = 1'b1; byteCount = CNT_W'(n); end
    @(negedge clk) startReq = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rstN) begin
    if (frameDone) doneSeen++;
    if (txStrobe) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected byte", txByte, 0);
      end else begin
        logic [7:0] e;
        bit ed;
        string t;
        e = expQ.pop_front();
        ed = expDoneQ.pop_front();
        t = expTagQ.pop_front();
        chk(txByte == e, t, txByte, e);
        chk(frameDone == ed, "R8 done flag", frameDone, ed);
      end
    end else begin
      chk(!frameDone, "R8 done without byte", frameDone, 0);
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errCnt++;
      vecCnt++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    int tot;
    int base;
    logic [7:0] payA [];
    logic [7:0] payB [];
    logic [7:0] payC [];
    logic [7:0] payZ [];

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!txStrobe, "R1 txStrobe", txStrobe, 0);
    chk(!sendEnable, "R1 sendEnable", sendEnable, 0);
    chk(!frameDone, "R1 frameDone", frameDone, 0);
    chk(!payloadRead, "R1 payloadRead", payloadRead, 0);
    @(negedge clk) rstN = 1'b1;

    // R1 nothing pending: idle request makes no byte
    giveReady(1, 1);
    chk(!sendEnable, "R1 idle request", sendEnable, 0);

    // frame A: no DLE, gapped requests
    payA = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36};
    base = rdIdx;
    planFrame(payA, tot);
    startBuf(6);
    giveReady(tot, 2);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R2 frame A drained", expQ.size(), 0);
    chk(rdIdx - base == 6, "R4 frame A reads", rdIdx - base, 6);
    chk(sendEnable, "R9 enable held after frame", sendEnable, 1);

    // frame B: DLE runs incl. last byte, back-to-back, start mid-frame ignored
    payB = '{8'h10, 8'h41, 8'h10, 8'h10, 8'h10};
    base = rdIdx;
    planFrame(payB, tot);
    startBuf(5);
    giveReady(4, 0);
    startBuf(2);
    giveReady(tot - 4, 0);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R5 frame B drained", expQ.size(), 0);
    chk(rdIdx - base == 5, "R5 frame B reads", rdIdx - base, 5);
    // R10 mid-frame start left nothing pending: next request drops enable
    giveReady(1, 2);
    chk(!sendEnable, "R10 R9 enable dropped", sendEnable, 0);
    chk(expQ.size() == 0, "R10 no extra frame", expQ.size(), 0);

    // frame Z: zero length
    payZ = new[0];
    base = rdIdx;
    planFrame(payZ, tot);
    startBuf(0);
    giveReady(tot, 1);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R11 empty frame drained", expQ.size(), 0);
    chk(rdIdx == base, "R11 no reads", rdIdx - base, 0);

    // frame C: start and request in the same idle cycle
    payC = '{8'hA5, 8'h10};
    base = rdIdx;
    planFrame(payC, tot);
    @(negedge clk) begin startReq = 1'b1; byteCount = CNT_W'(2); txReady = 1'b1; end
    @(negedge clk) begin startReq = 1'b0; txReady = 1'b0; end
    chk(sendEnable, "R12 enable on same-cycle start", sendEnable, 1);
    giveReady(tot - 1, 0);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R12 frame C drained", expQ.size(), 0);
    chk(rdIdx - base == 2, "R12 frame C reads", rdIdx - base, 2);
    chk(doneSeen == 4, "R8 completion count", doneSeen, 4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule